// File: doc/BRIEF.md
# Counter-Array Watchdog Timer

This block is a watchdog built on a shared 16-bit counter and one 16-bit compare
module. When the watchdog is on, the compare module's upper byte is a deadline. Its
lower byte is an offset that software programs. The watchdog is serviced by writing
any value to the deadline register. The block then loads the deadline with the
counter's current upper byte plus the offset, wrapping at 8 bits.

The compare is made only at the clock where the counter's lower byte rolls over from
all ones to zero. At that clock, the deadline is compared with the counter's upper
byte as it was just before the rollover. A match raises a one-clock reset pulse, and
that pulse also returns every register to its reset value, so the watchdog comes back
on. While the watchdog is on, it takes over the shared counter controls and locks them:

- the counter runs,
- counter writes are dropped,
- the clock-select and idle fields are frozen,
- the module mode register reports a fixed software-timer code.

The counter advances only on a one-cycle `tick` enable, which stands in for the
selected clock source.

Top module: `cawdt_top`

## Requirements
- R1: After `rst`, the registers read as follows: configuration (address 0) reads 0x01, meaning the watchdog is on, idle is 0 and the clock select is 0. Run (address 1), counter low (2), counter high (3), offset (4) and deadline (5) all read 0x00, and mode (6) reads 0x49.
- R2: The counter advances by one on each clock where `tick` is high and the counter is running. It carries from the low byte into the high byte and wraps at 16 bits. With the watchdog off and the run bit (address 1, bit 0) clear, the counter holds its value.
- R3: Any write to address 5 while the watchdog is on loads the deadline with (counter high byte + offset) mod 256, and the written data is discarded. With the watchdog off, the same write stores the data.
- R4: While the watchdog is on, the counter advances on every `tick` whatever the run bit holds, and writes to the run bit do not stop it.
- R5: The run bit reads back only what software last wrote to it. It therefore reads zero when the watchdog is on but software has not set it.
- R6: Writes to addresses 2 and 3 are ignored while the watchdog is on. With the watchdog off, they replace that byte, and the counter does not advance in the cycle of the write.
- R7: While the watchdog is on, writes to address 6 are dropped and it reads 0x49 (software-timer code). With the watchdog off, it stores and reads back the written byte.
- R8: Configuration bit 0 is the watchdog enable, bit 1 the idle control and bits 4:2 the clock select. While the watchdog is on, a configuration write takes effect only when it has bit 0 = 0 and bits 4:1 equal to the stored value; such a write turns the watchdog off. Every other configuration write is ignored in full. With the watchdog off, all five bits are writable.
- R9: A match is checked only on the tick that rolls the low byte from 0xFF to 0x00, comparing the deadline with the high byte before the increment. The reset fires after exactly 256·offset + 256 − L ticks from a service done at low byte L.
- R10: `wdt_reset` is high for exactly one clock, in the cycle after the matching tick's edge. In that cycle every register already holds its R1 value.
- R11: The clock-select and idle fields are stored and read back only; they do not change how the counter advances.
- R12: `rd_data` shows the register at `rd_addr` one clock after it is presented. Address 7 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle counter advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Registered read data |
| wdt_reset | output | 1 | One-clock watchdog reset pulse |

## Verification
The assertions assume that `tick`, `wr_en` and the addresses are synchronous to `clk` and that `rst` is synchronous. They also take the written address to be the one that decides the effect, with at most one write per clock. The stimulus changes inputs only on the falling edge and keeps `tick` low during register accesses, except where a run of ticks is the point of the test. Timeout lengths are therefore counted as whole ticks from a known low byte.

// File: rtl/cawdt_pkg.sv
package cawdt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CFG  = 3'd0,
    RA_RUN  = 3'd1,
    RA_CLO  = 3'd2,
    RA_CHI  = 3'd3,
    RA_OFS  = 3'd4,
    RA_DLN  = 3'd5,
    RA_MODE = 3'd6,
    RA_NONE = 3'd7
  } reg_addr_e;

  // code reported by the mode register while the watchdog owns the module
  localparam logic [7:0] MODE_SWTMR = 8'h49;

  typedef struct packed {
    logic [2:0] clksel;
    logic       idle;
    logic       wd_en;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
  localparam cfg_t CFG_RST = '{clksel: 3'd0, idle: 1'b0, wd_en: 1'b1};
endpackage

// File: rtl/cawdt_cfg.sv
module cawdt_cfg
  import cawdt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              we_cfg,
  input  logic              we_run,
  input  logic              we_mode,
  input  logic [BYTE_W-1:0] wr_data,
  output cfg_t              cfg,
  output logic              sw_run,
  output logic [BYTE_W-1:0] mode_rd
);
  localparam logic [BYTE_W-1:0] SWT = BYTE_W'(MODE_SWTMR);

  logic [BYTE_W-1:0] mode_q;
  cfg_t              wr_cfg;
  logic              disable_ok;

  assign wr_cfg     = cfg_t'(wr_data[CFG_W-1:0]);
  assign disable_ok = !wr_cfg.wd_en &&
                      (wr_cfg.clksel == cfg.clksel) && (wr_cfg.idle == cfg.idle);

  always_ff @(posedge clk) begin
    if (clr) begin
      cfg    <= CFG_RST;
      sw_run <= 1'b0;
      mode_q <= '0;
    end else begin
      if (we_cfg) begin
        if (!cfg.wd_en) cfg <= wr_cfg;
        else if (disable_ok) cfg.wd_en <= 1'b0;
      end
      if (we_run) sw_run <= wr_data[0];
      if (we_mode && !cfg.wd_en) mode_q <= wr_data;
    end
  end

  assign mode_rd = cfg.wd_en ? SWT : mode_q;
endmodule

// File: rtl/cawdt_counter.sv
module cawdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               run,
  input  logic               tick,
  input  logic               lock,
  input  logic               we_lo,
  input  logic               we_hi,
  input  logic [CNT_W/2-1:0] wr_data,
  output logic [CNT_W-1:0]   cnt,
  output logic               lo_ovf
);
  localparam int BYTE_W = CNT_W / 2;

  logic wr_any;
  assign wr_any = !lock && (we_lo || we_hi);
  assign lo_ovf = run && tick && (&cnt[BYTE_W-1:0]);

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt <= '0;
    end else if (wr_any) begin
      if (we_lo) cnt[BYTE_W-1:0]     <= wr_data;
      if (we_hi) cnt[CNT_W-1:BYTE_W] <= wr_data;
    end else if (run && tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cawdt_guard.sv
module cawdt_guard #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              wd_en,
  input  logic              we_ofs,
  input  logic              we_dln,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] cnt_hi,
  input  logic              lo_ovf,
  output logic [BYTE_W-1:0] offset,
  output logic [BYTE_W-1:0] deadline,
  output logic              fire
);
  logic [BYTE_W-1:0] reload;
  assign reload = cnt_hi + offset;
  assign fire   = wd_en && lo_ovf && (deadline == cnt_hi);

  always_ff @(posedge clk) begin
    if (clr) begin
      offset   <= '0;
      deadline <= '0;
    end else begin
      if (we_ofs) offset <= wr_data;
      if (we_dln) deadline <= wd_en ? reload : wr_data;
    end
  end
endmodule

// File: rtl/cawdt_top.sv
module cawdt_top
  import cawdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [CNT_W/2-1:0]   wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [CNT_W/2-1:0]   rd_data,
  output logic                 wdt_reset
);
  localparam int BYTE_W = CNT_W / 2;

  reg_addr_e         wa, ra;
  logic              clr, fire, lo_ovf, sw_run, wd_en;
  cfg_t              cfg;
  logic [BYTE_W-1:0] mode_rd, offset, deadline;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rd_next;

  assign wa    = reg_addr_e'(wr_addr);
  assign ra    = reg_addr_e'(rd_addr);
  assign clr   = rst || fire;
  assign wd_en = cfg.wd_en;

  cawdt_cfg #(.BYTE_W(BYTE_W)) u_cfg (
    .clk(clk), .clr(clr),
    .we_cfg(wr_en && wa == RA_CFG),
    .we_run(wr_en && wa == RA_RUN),
    .we_mode(wr_en && wa == RA_MODE),
    .wr_data(wr_data), .cfg(cfg), .sw_run(sw_run), .mode_rd(mode_rd)
  );

  cawdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .clr(clr), .run(sw_run || wd_en), .tick(tick), .lock(wd_en),
    .we_lo(wr_en && wa == RA_CLO), .we_hi(wr_en && wa == RA_CHI),
    .wr_data(wr_data), .cnt(cnt), .lo_ovf(lo_ovf)
  );

  cawdt_guard #(.BYTE_W(BYTE_W)) u_guard (
    .clk(clk), .clr(clr), .wd_en(wd_en),
    .we_ofs(wr_en && wa == RA_OFS), .we_dln(wr_en && wa == RA_DLN),
    .wr_data(wr_data), .cnt_hi(cnt[CNT_W-1:BYTE_W]), .lo_ovf(lo_ovf),
    .offset(offset), .deadline(deadline), .fire(fire)
  );

  always_comb begin
    rd_next = '0;
    unique case (ra)
      RA_CFG:  rd_next = BYTE_W'(cfg);
      RA_RUN:  rd_next = BYTE_W'(sw_run);
      RA_CLO:  rd_next = cnt[BYTE_W-1:0];
      RA_CHI:  rd_next = cnt[CNT_W-1:BYTE_W];
      RA_OFS:  rd_next = offset;
      RA_DLN:  rd_next = deadline;
      RA_MODE: rd_next = mode_rd;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      wdt_reset <= 1'b0;
    end else begin
      rd_data   <= rd_next;
      wdt_reset <= fire;
    end
  end
endmodule

// File: rtl/cawdt_chk.sv
module cawdt_chk #(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic               wr_en,
  input logic [2:0]         wr_addr,
  input logic               wdt_reset,
  input logic               wd_en,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W/2-1:0] offset,
  input logic [CNT_W/2-1:0] deadline
);
  localparam int BYTE_W = CNT_W / 2;

  logic [BYTE_W-1:0] exp_dl;
  logic [CNT_W-1:0]  cnt_inc;
  logic              match_now;
  assign exp_dl    = cnt[CNT_W-1:BYTE_W] + offset;
  assign cnt_inc   = cnt + 1'b1;
  assign match_now = wd_en && tick && (&cnt[BYTE_W-1:0]) &&
                     (deadline == cnt[CNT_W-1:BYTE_W]);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    wdt_reset |=> !wdt_reset);

  assert_restore_R10: assert property (@(posedge clk) disable iff (rst)
    wdt_reset |-> (wd_en && cnt == '0 && offset == '0 && deadline == '0));

  assert_forced_run_R4: assert property (@(posedge clk) disable iff (rst)
    (wd_en && tick) |=> (wdt_reset || cnt == $past(cnt_inc)));

  assert_cnt_locked_R6: assert property (@(posedge clk) disable iff (rst)
    (wd_en && !tick) |=> $stable(cnt));

  assert_service_R3: assert property (@(posedge clk) disable iff (rst)
    (wd_en && wr_en && wr_addr == 3'd5) |=> (wdt_reset || deadline == $past(exp_dl)));

  assert_fire_cause_R9: assert property (@(posedge clk) disable iff (rst)
    wdt_reset |-> $past(match_now));

  assert_fire_taken_R9: assert property (@(posedge clk) disable iff (rst)
    match_now |=> wdt_reset);
endmodule

bind cawdt_top cawdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .wdt_reset(wdt_reset), .wd_en(wd_en), .cnt(cnt), .offset(offset),
  .deadline(deadline)
);

// File: tb/cawdt_top_tb.sv
module cawdt_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       wdt_reset;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cawdt_top u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .wdt_reset(wdt_reset)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    #1 d = rd_data;
  endtask

  task automatic expect_reg(input string tag, input logic [2:0] a, input logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    check(tag, int'(v), int'(e));
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  // ticks until wdt_reset is seen (0 if none within max)
  task automatic wait_fire(input int max, output int n);
    n = 0;
    @(negedge clk);
    tick = 1'b1;
    for (int i = 1; i <= max; i++) begin
      @(posedge clk);
      #1;
      if (wdt_reset) begin
        n = i;
        break;
      end
    end
    tick = 1'b0;
  endtask

  task automatic t_reset;
    expect_reg("R1 cfg", 3'd0, 8'h01);
    expect_reg("R1 run", 3'd1, 8'h00);
    expect_reg("R1 cnt_lo", 3'd2, 8'h00);
    expect_reg("R1 cnt_hi", 3'd3, 8'h00);
    expect_reg("R1 offset", 3'd4, 8'h00);
    expect_reg("R1 deadline", 3'd5, 8'h00);
    expect_reg("R1 mode", 3'd6, 8'h49);
    check("R10 no pulse after reset", int'(wdt_reset), 0);
  endtask

  task automatic t_forced_run;
    run_ticks(10);
    expect_reg("R4 counts with run clear", 3'd2, 8'h0A);
    expect_reg("R5 run reads zero", 3'd1, 8'h00);
    wr(3'd1, 8'h01);
    expect_reg("R5 run reads set", 3'd1, 8'h01);
    wr(3'd1, 8'h00);
    run_ticks(5);
    expect_reg("R4 still counts after run cleared", 3'd2, 8'h0F);
  endtask

  task automatic t_locks;
    wr(3'd2, 8'h77);
    expect_reg("R6 lo write ignored", 3'd2, 8'h0F);
    wr(3'd3, 8'h33);
    expect_reg("R6 hi write ignored", 3'd3, 8'h00);
    wr(3'd0, 8'h1D);
    expect_reg("R7 cfg fields frozen", 3'd0, 8'h01);
    wr(3'd6, 8'h12);
    expect_reg("R7 mode write blocked", 3'd6, 8'h49);
    wr(3'd0, 8'h02);
    expect_reg("R8 disable with field change ignored", 3'd0, 8'h01);
  endtask

  task automatic t_free;
    wr(3'd0, 8'h00);
    expect_reg("R8 disable honoured", 3'd0, 8'h00);
    expect_reg("R7 mode stored value", 3'd6, 8'h00);
    wr(3'd6, 8'h12);
    expect_reg("R7 mode writable when off", 3'd6, 8'h12);
    wr(3'd0, 8'h1E);
    expect_reg("R11 clksel idle stored", 3'd0, 8'h1E);
    run_ticks(8);
    expect_reg("R2 holds with run clear", 3'd2, 8'h0F);
    wr(3'd2, 8'hFE);
    wr(3'd3, 8'h01);
    expect_reg("R6 lo written when off", 3'd2, 8'hFE);
    expect_reg("R6 hi written when off", 3'd3, 8'h01);
    wr(3'd1, 8'h01);
    run_ticks(3);
    expect_reg("R2 carry lo", 3'd2, 8'h01);
    expect_reg("R2 carry hi", 3'd3, 8'h02);
    wr(3'd5, 8'h5A);
    expect_reg("R3 deadline stores data when off", 3'd5, 8'h5A);
    wr(3'd4, 8'h02);
    expect_reg("R3 offset stored", 3'd4, 8'h02);
  endtask

  task automatic t_timeout;
    int n;
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h40);
    wr(3'd3, 8'h10);
    wr(3'd0, 8'h1F);
    expect_reg("R8 re-enable keeps fields", 3'd0, 8'h1F);
    wr(3'd5, 8'hEE);
    expect_reg("R3 service reload", 3'd5, 8'h12);
    wait_fire(2000, n);
    check("R9 timeout off=2 L=0x40", n, 704);
    @(posedge clk);
    #1 check("R10 pulse one clock", int'(wdt_reset), 0);
    expect_reg("R10 cfg restored", 3'd0, 8'h01);
    expect_reg("R10 offset restored", 3'd4, 8'h00);
    expect_reg("R10 mode forced", 3'd6, 8'h49);
    expect_reg("R10 counter cleared", 3'd3, 8'h00);
  endtask

  task automatic t_wrap;
    int n;
    wait_fire(1000, n);
    check("R9 timeout off=0 L=0", n, 256);
    wr(3'd4, 8'hFF);
    wr(3'd5, 8'h00);
    expect_reg("R3 service from zero", 3'd5, 8'hFF);
    wait_fire(260, n);
    check("R9 no fire before deadline", n, 0);
    wr(3'd5, 8'h00);
    expect_reg("R3 wrapping adder", 3'd5, 8'h00);
    wait_fire(70000, n);
    check("R9 timeout off=0xFF L=4", n, 65532);
    expect_reg("R12 unused address", 3'd7, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_forced_run();
    t_locks();
    t_free();
    t_timeout();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule